// File: doc/BRIEF.md
# Requester Identifier Range Translator

This block sits between a PCIe root complex and a set of IOMMUs. For every inbound transaction it takes the 16-bit requester identifier and works out which IOMMU should handle it and what sideband specifier that IOMMU receives. In the identifier, the bus number is in bits [15:8], the device number in bits [7:3] and the function number in bits [2:0]. Any bits above bit 15 count as zero. The block first ANDs the identifier with a programmable mask. It then looks the masked value up in a small table of range entries. Each entry carries a base, a length, a target IOMMU index and a specifier base.

Lookups travel over a valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its result appears on the response port one clock later. The response port holds one result. While a response is pending and `rsp_ready` is low, `req_ready` stays low and the response does not change. So back-pressure from the consumer reaches the requester in the same cycle. The table and the mask are loaded through a plain, single-cycle write port. A lookup uses the table contents at the edge where it is accepted.

Top module: `rid_xlate_table`

## Requirements
- R1: After reset no response is pending, `req_ready` is high, the mask is all ones and every entry is invalid, so any lookup faults.
- R2: The identifier is ANDed with the mask before any comparison. With a mask of 0xFFF8, every function of a device gives the same specifier.
- R3: An entry matches a masked identifier r only when base <= r < base + length. Its first identifier matches, its last identifier (base + length - 1) matches, and base + length does not.
- R4: On a hit, the specifier is (r - base + specifier base) modulo 2^16. This allows non-identity remaps, such as swapping the two halves of the identifier space.
- R5: On a hit, `rsp_tgt` carries the target index stored in the matching entry.
- R6: An entry whose valid bit is clear never matches.
- R7: When several valid entries match, the entry with the lowest index wins.
- R8: When no valid entry matches, `rsp_fault` is 1 and both `rsp_tgt` and `rsp_spec` are 0. On a hit, `rsp_fault` is 0.
- R9: The length field is 17 bits wide. An entry with base 0 and length 0x10000 covers every identifier up to and including 0xFFFF.
- R10: `rsp_valid` rises in the clock after a request is accepted. The rules for `req_ready` and for holding a pending response are given in the description above. A response is retired on an edge with `rsp_ready` high.
- R11: A write with `cfg_we` high updates one field, chosen by `cfg_field`, of entry `cfg_idx`. The field codes are: 0 = base (`cfg_wdata[15:0]`), 1 = length (`cfg_wdata[16:0]`), 2 = specifier base (`cfg_wdata[15:0]`), 3 = control (target in `cfg_wdata[TGT_W-1:0]`, valid in `cfg_wdata[16]`), 4 = mask (`cfg_wdata[15:0]`, `cfg_idx` ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (3) | Entry index for the write |
| cfg_field | input | 3 | Field code for the write |
| cfg_wdata | input | 17 | Write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_rid | input | 16 | Requester identifier |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | No entry matched |
| rsp_tgt | output | TGT_W (2) | Target IOMMU index |
| rsp_spec | output | 16 | Sideband specifier |

## Verification
The bench checks entry boundaries on both sides of the interval. A design with an inclusive upper bound would hit on base + length, and one with an off-by-one lower compare would miss on base. Overlapping entries are used to show that the lowest index wins; a design with the priority reversed returns the other entry's specifier and target. A full-length entry ending at 0xFFFF exposes a truncated length or sum, which would fault on the top identifier. A half-swap remap checks the wrap-around arithmetic. A stalled consumer checks that the result does not change and that intake is blocked; a design that drops or overwrites a pending result fails there. The mask test and the cleared-valid test expose a design that compares unmasked identifiers or that ignores the valid bit.

// File: rtl/rid_xlate_pkg.sv
package rid_xlate_pkg;
  localparam int RID_W = 16;
  localparam int LEN_W = 17;
  localparam int SUM_W = 18;

  typedef enum logic [2:0] {
    FLD_BASE = 3'd0,
    FLD_LEN  = 3'd1,
    FLD_SPEC = 3'd2,
    FLD_CTRL = 3'd3,
    FLD_MASK = 3'd4
  } fld_e;
endpackage

// File: rtl/rid_xlate_regs.sv
module rid_xlate_regs
  import rid_xlate_pkg::*;
#(
  parameter int N     = 8,
  parameter int TGT_W = 2,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [2:0]       field,
  input  logic [LEN_W-1:0] wdata,
  output logic [RID_W-1:0] mask_o,
  output logic [RID_W-1:0] base_o [N],
  output logic [LEN_W-1:0] len_o  [N],
  output logic [RID_W-1:0] spec_o [N],
  output logic [TGT_W-1:0] tgt_o  [N],
  output logic             vld_o  [N]
);
  fld_e fld;
  assign fld = fld_e'(field);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '1;
      for (int i = 0; i < N; i++) begin
        base_o[i] <= '0;
        len_o[i]  <= '0;
        spec_o[i] <= '0;
        tgt_o[i]  <= '0;
        vld_o[i]  <= 1'b0;
      end
    end else if (we) begin
      if (fld == FLD_MASK) mask_o <= wdata[RID_W-1:0];
      for (int i = 0; i < N; i++) begin
        if (idx == IDX_W'(i)) begin
          case (fld)
            FLD_BASE: base_o[i] <= wdata[RID_W-1:0];
            FLD_LEN:  len_o[i]  <= wdata;
            FLD_SPEC: spec_o[i] <= wdata[RID_W-1:0];
            FLD_CTRL: begin
              tgt_o[i] <= wdata[TGT_W-1:0];
              vld_o[i] <= wdata[LEN_W-1];
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/rid_xlate_match.sv
module rid_xlate_match
  import rid_xlate_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [RID_W-1:0] rid,
  input  logic [RID_W-1:0] base [N],
  input  logic [LEN_W-1:0] len  [N],
  input  logic             vld  [N],
  output logic [N-1:0]     hit
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [SUM_W-1:0] lim;
    logic             above, below;
    assign lim   = SUM_W'(base[g]) + SUM_W'(len[g]);
    assign above = rid >= base[g];
    assign below = SUM_W'(rid) < lim;
    assign hit[g] = vld[g] & above & below;
  end
endmodule

// File: rtl/rid_xlate_pick.sv
module rid_xlate_pick
  import rid_xlate_pkg::*;
#(
  parameter int N     = 8,
  parameter int TGT_W = 2,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hit,
  input  logic [RID_W-1:0] rid,
  input  logic [RID_W-1:0] base [N],
  input  logic [RID_W-1:0] spec [N],
  input  logic [TGT_W-1:0] tgt  [N],
  output logic             any_o,
  output logic [TGT_W-1:0] tgt_o,
  output logic [RID_W-1:0] spec_o
);
  logic [IDX_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) sel = IDX_W'(i);
    end
  end

  assign any_o  = |hit;
  assign tgt_o  = tgt[sel];
  assign spec_o = rid - base[sel] + spec[sel];
endmodule

// File: rtl/rid_xlate_table.sv
module rid_xlate_table
  import rid_xlate_pkg::*;
#(
  parameter int N     = 8,
  parameter int TGT_W = 2,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [2:0]       cfg_field,
  input  logic [16:0]      cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_rid,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [TGT_W-1:0] rsp_tgt,
  output logic [15:0]      rsp_spec
);
  logic [RID_W-1:0] mask;
  logic [RID_W-1:0] base [N];
  logic [LEN_W-1:0] len  [N];
  logic [RID_W-1:0] spec [N];
  logic [TGT_W-1:0] tgt  [N];
  logic             vld  [N];
  logic [N-1:0]     hit;
  logic             any;
  logic [TGT_W-1:0] p_tgt;
  logic [RID_W-1:0] p_spec;
  logic [RID_W-1:0] rid_m;
  logic             accept;

  rid_xlate_regs #(.N(N), .TGT_W(TGT_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .field(cfg_field),
    .wdata(cfg_wdata), .mask_o(mask), .base_o(base), .len_o(len),
    .spec_o(spec), .tgt_o(tgt), .vld_o(vld)
  );

  assign rid_m = req_rid & mask;

  rid_xlate_match #(.N(N)) u_match (
    .rid(rid_m), .base(base), .len(len), .vld(vld), .hit(hit)
  );

  rid_xlate_pick #(.N(N), .TGT_W(TGT_W), .IDX_W(IDX_W)) u_pick (
    .hit(hit), .rid(rid_m), .base(base), .spec(spec), .tgt(tgt),
    .any_o(any), .tgt_o(p_tgt), .spec_o(p_spec)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_tgt   <= '0;
      rsp_spec  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= !any;
      rsp_tgt   <= any ? p_tgt  : '0;
      rsp_spec  <= any ? p_spec : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rid_xlate_chk.sv
module rid_xlate_chk #(
  parameter int TGT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [TGT_W-1:0] rsp_tgt,
  input logic [15:0]      rsp_spec
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_spec) && $stable(rsp_tgt) && $stable(rsp_fault)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R10
  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) && !(rsp_valid && !rsp_ready) |=> !rsp_valid); // R10
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_spec == 16'h0 && rsp_tgt == '0); // R8
endmodule

bind rid_xlate_table rid_xlate_chk #(.TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_tgt(rsp_tgt), .rsp_spec(rsp_spec)
);

// File: tb/sim_rid_xlate_table.sv
`timescale 1ns/1ps
module sim_rid_xlate_table;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_idx = 0;
  logic [2:0]  cfg_field = 0;
  logic [16:0] cfg_wdata = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [15:0] req_rid = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic        rsp_fault;
  logic [1:0]  rsp_tgt;
  logic [15:0] rsp_spec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rid_xlate_table u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_rid(req_rid), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_tgt(rsp_tgt),
    .rsp_spec(rsp_spec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int fld, input logic [16:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_field = 3'(fld); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic entry(input int idx, input logic [15:0] b, input logic [16:0] l,
                       input logic [15:0] s, input logic [1:0] t, input bit v);
    wr(idx, 0, {1'b0, b});
    wr(idx, 1, l);
    wr(idx, 2, {1'b0, s});
    wr(idx, 3, {v, 14'h0, t});
  endtask

  task automatic look(input string req, input logic [15:0] rid, input bit f,
                      input logic [1:0] t, input logic [15:0] s);
    @(negedge clk);
    rsp_ready = 1; req_valid = 1; req_rid = rid;
    @(negedge clk);
    req_valid = 0;
    check({req, " valid"}, 32'(rsp_valid), 32'(1));
    check({req, " fault"}, 32'(rsp_fault), 32'(f));
    check({req, " tgt"},   32'(rsp_tgt),   32'(t));
    check({req, " spec"},  32'(rsp_spec),  32'(s));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", 32'(rsp_valid), 32'(0));
    check("R1 ready", 32'(req_ready), 32'(1));
    look("R1 R8 empty table", 16'h1234, 1, 0, 0);
  endtask

  task automatic t_bounds;
    entry(0, 16'h0100, 17'h10, 16'h0500, 2'd1, 1);
    look("R3 R11 first", 16'h0100, 0, 1, 16'h0500);
    look("R3 last", 16'h010F, 0, 1, 16'h050F);
    look("R3 end excl", 16'h0110, 1, 0, 0);
    look("R3 below", 16'h00FF, 1, 0, 0);
  endtask

  task automatic t_mask;
    wr(0, 4, 17'h0FFF8);
    look("R2 fn7", 16'h0107, 0, 1, 16'h0500);
    look("R2 dev1", 16'h010D, 0, 1, 16'h0508);
    wr(5, 4, 17'h0FFFF);
    look("R2 unmasked", 16'h0107, 0, 1, 16'h0507);
  endtask

  task automatic t_invalid;
    wr(0, 3, 17'h00001);
    look("R6 cleared", 16'h0100, 1, 0, 0);
  endtask

  task automatic t_priority;
    entry(2, 16'h2000, 17'h100, 16'h0000, 2'd2, 1);
    entry(1, 16'h2080, 17'h100, 16'h7000, 2'd3, 1);
    look("R7 overlap", 16'h2090, 0, 3, 16'h7010);
    look("R5 entry2 only", 16'h2010, 0, 2, 16'h0010);
    look("R5 entry1 only", 16'h2150, 0, 3, 16'h70D0);
    wr(1, 3, 17'h0);
    wr(2, 3, 17'h0);
  endtask

  task automatic t_swap;
    entry(3, 16'h0000, 17'h8000, 16'h8000, 2'd0, 1);
    entry(4, 16'h8000, 17'h8000, 16'h0000, 2'd1, 1);
    look("R4 low half", 16'h1234, 0, 0, 16'h9234);
    look("R4 high half", 16'h8001, 0, 1, 16'h0001);
    look("R4 top", 16'hFFFF, 0, 1, 16'h7FFF);
    wr(3, 3, 17'h0);
    wr(4, 3, 17'h0);
  endtask

  task automatic t_full;
    entry(7, 16'h0000, 17'h10000, 16'h0000, 2'd2, 1);
    look("R9 top id", 16'hFFFF, 0, 2, 16'hFFFF);
    look("R9 zero", 16'h0000, 0, 2, 16'h0000);
  endtask

  task automatic t_stall;
    logic [15:0] held;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_rid = 16'h00AB;
    @(negedge clk);
    req_rid = 16'h0CDE;
    check("R10 valid after accept", 32'(rsp_valid), 32'(1));
    check("R10 ready low", 32'(req_ready), 32'(0));
    held = rsp_spec;
    check("R10 spec", 32'(held), 32'h00AB);
    repeat (3) @(negedge clk);
    check("R10 held", 32'(rsp_spec), 32'(held));
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    check("R10 retired", 32'(rsp_valid), 32'(0));
    check("R10 second not taken", 32'(rsp_spec), 32'h00AB);
  endtask

  initial begin
    t_reset;
    t_bounds;
    t_mask;
    t_invalid;
    t_priority;
    t_swap;
    t_full;
    t_stall;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule